// File: doc/BRIEF.md
# Instruction Stream Color Validation Unit

This unit lets a fetch front end prefetch past a branch to any depth without knowing how many of those fetches will be wanted. It keeps a single stream color bit and tags each fetch request with it. Returned instructions queue in an instruction FIFO, and the addresses of the same fetches queue in a separate PC FIFO in the same order. At the decode point, an entry whose color differs from the current stream color is thrown away. An entry whose color matches is presented downstream together with its address and with the address plus 8, which is the value an instruction sees when it reads the program counter. A failed fetch comes back as a void entry. It raises a prefetch trap only if its color matches at decode.

Load/store instructions are tracked until memory answers. When a load/store is accepted at decode, its PC moves into an exception FIFO and no younger instruction is released. A no-abort answer retires the entry. An abort answer copies the entry into an exception latch, raises a data-abort request carrying the return address, and flips the stream color at once, so every younger instruction already queued is discarded. At the result stage a commit is allowed to write only if its color still matches.

Top module: `scu_top`

## Requirements
- R1: After reset the stream color is 0, both FIFOs are empty (fetch_ready high, dec_valid and dec_trap low), no load/store is pending (mem_ready low), and dabt_req is low.
- R2: fetch_color shows the stream color that tags each accepted fetch. A br_taken pulse toggles it at the next clock edge, and so does an accepted abort response.
- R3: A queued instruction whose return color differs from fetch_color is removed at decode without raising dec_valid or dec_trap, and its PC entry is removed with it.
- R4: A void return (ret_void=1) with a matching color raises dec_trap instead of dec_valid. A void return with a mismatched color is dropped without a trap.
- R5: dec_pc is the fetch address paired in order with the presented instruction, and dec_pc_op equals dec_pc plus 8.
- R6: fetch_ready is low while the PC FIFO holds DEPTH entries (default 4). This bounds the prefetch depth.
- R7: A load/store accepted at decode (dec_valid, dec_ready and dec_is_ls all high) pushes its PC into the exception FIFO and raises mem_ready. Until the memory answers, dec_valid and dec_trap stay low.
- R8: A no-abort answer (mem_valid=1, mem_abort=0) retires the oldest pending entry and releases decode without raising dabt_req.
- R9: An abort answer sets dabt_req at the next edge with dabt_ret equal to the load/store PC plus 8, and flips the stream color at the same edge so that queued younger instructions are dropped. dabt_ack clears dabt_req.
- R10: cm_write is high exactly when cm_valid is high and cm_color equals the stream color.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request from the front end |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_ready | output | 1 | Fetch may be issued (PC FIFO not full) |
| fetch_color | output | 1 | Current stream color, tag for the fetch |
| ret_valid | input | 1 | Fetched word returning |
| ret_insn | input | INSN_W | Returned instruction word |
| ret_color | input | 1 | Color tag echoed with the return |
| ret_void | input | 1 | Fetch failed, data is void |
| ret_ready | output | 1 | Instruction FIFO can accept |
| dec_valid | output | 1 | Matching instruction presented to decode |
| dec_trap | output | 1 | Matching void fetch: prefetch trap |
| dec_insn | output | INSN_W | Presented instruction word |
| dec_pc | output | PC_W | Address of the presented entry |
| dec_pc_op | output | PC_W | Address plus 8, PC operand value |
| dec_is_ls | input | 1 | Presented instruction is a load/store |
| dec_ready | input | 1 | Decode accepts the presented entry |
| br_taken | input | 1 | Taken branch pulse |
| cm_valid | input | 1 | Result stage wants to commit |
| cm_color | input | 1 | Color of the committing result |
| cm_write | output | 1 | Commit is allowed to write |
| mem_valid | input | 1 | Memory response for oldest load/store |
| mem_abort | input | 1 | Response is an abort |
| mem_ready | output | 1 | A load/store awaits its response |
| dabt_req | output | 1 | Data-abort request |
| dabt_ret | output | PC_W | Return address for the data abort |
| dabt_ack | input | 1 | Abort request taken |

## Verification
The stimulus table sends returns in four patterns: matching and mismatched colors, each with and without the void flag, before and after branches. This separates the normal path, silent drops, real prefetch traps and suppressed traps. Directed sequences fill the PC FIFO to show the issue stall. They pair a load/store with a younger instruction under a no-abort answer and then under an abort answer. The first case shows the hold and the release. The second shows the color flip that drops the held younger entry and the return address that comes out. Commit checks use both colors against the current stream color.

// File: rtl/scu_pkg.sv
package scu_pkg;
  localparam int PC_AHEAD = 8;

  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_DROP  = 2'd1,
    DEC_ISSUE = 2'd2,
    DEC_TRAP  = 2'd3
  } dec_kind_e;

  // Outcome of the decode point for the head entry.
  function automatic dec_kind_e classify(input logic have, input logic match,
                                         input logic is_void, input logic hold);
    if (!have)        return DEC_NONE;
    else if (!match)  return DEC_DROP;
    else if (hold)    return DEC_NONE;
    else if (is_void) return DEC_TRAP;
    else              return DEC_ISSUE;
  endfunction
endpackage

// File: rtl/scu_fifo.sv
module scu_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rp];

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/scu_xcpt.sv
module scu_xcpt #(
  parameter int PC_W   = 32,
  parameter int XDEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ls_push,
  input  logic [PC_W-1:0] ls_pc,
  input  logic            mem_valid,
  input  logic            mem_abort,
  input  logic            dabt_ack,
  output logic            mem_ready,
  output logic            x_full,
  output logic            abort_evt,
  output logic            dabt_req,
  output logic [PC_W-1:0] dabt_ret
);
  logic [PC_W-1:0] x_head, latched_pc;
  logic            x_empty, resp_take;

  assign mem_ready = !x_empty;
  assign resp_take = mem_valid && mem_ready;
  assign abort_evt = resp_take && mem_abort;

  scu_fifo #(.W(PC_W), .DEPTH(XDEPTH)) u_xfifo (
    .clk(clk), .rst_n(rst_n), .push(ls_push), .din(ls_pc),
    .pop(resp_take), .head(x_head), .full(x_full), .empty(x_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dabt_req   <= 1'b0;
      latched_pc <= '0;
    end else if (abort_evt) begin
      dabt_req   <= 1'b1;
      latched_pc <= x_head;
    end else if (dabt_ack) begin
      dabt_req   <= 1'b0;
    end
  end

  assign dabt_ret = latched_pc + PC_W'(scu_pkg::PC_AHEAD);
endmodule

// File: rtl/scu_top.sv
module scu_top #(
  parameter int PC_W   = 32,
  parameter int INSN_W = 32,
  parameter int DEPTH  = 4,
  parameter int XDEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              fetch_ready,
  output logic              fetch_color,
  input  logic              ret_valid,
  input  logic [INSN_W-1:0] ret_insn,
  input  logic              ret_color,
  input  logic              ret_void,
  output logic              ret_ready,
  output logic              dec_valid,
  output logic              dec_trap,
  output logic [INSN_W-1:0] dec_insn,
  output logic [PC_W-1:0]   dec_pc,
  output logic [PC_W-1:0]   dec_pc_op,
  input  logic              dec_is_ls,
  input  logic              dec_ready,
  input  logic              br_taken,
  input  logic              cm_valid,
  input  logic              cm_color,
  output logic              cm_write,
  input  logic              mem_valid,
  input  logic              mem_abort,
  output logic              mem_ready,
  output logic              dabt_req,
  output logic [PC_W-1:0]   dabt_ret,
  input  logic              dabt_ack
);
  import scu_pkg::*;
  localparam int EW = INSN_W + 2;

  function automatic logic [PC_W-1:0] pc_operand(input logic [PC_W-1:0] pc);
    return pc + PC_W'(PC_AHEAD);
  endfunction

  logic            color_q, color_flip;
  logic            pc_full, pc_empty, insn_full, insn_empty;
  logic [EW-1:0]   hd_entry;
  logic            hd_color, hd_void, hd_have;
  logic            dec_pop, ls_push, ls_pending, abort_evt, x_full;
  dec_kind_e       kind;

  // stream color
  assign color_flip = br_taken ^ abort_evt;
  always_ff @(posedge clk) begin
    if (!rst_n)          color_q <= 1'b0;
    else if (color_flip) color_q <= ~color_q;
  end
  assign fetch_color = color_q;

  scu_fifo #(.W(PC_W), .DEPTH(DEPTH)) u_pcq (
    .clk(clk), .rst_n(rst_n), .push(fetch_valid && fetch_ready), .din(fetch_pc),
    .pop(dec_pop), .head(dec_pc), .full(pc_full), .empty(pc_empty)
  );

  scu_fifo #(.W(EW), .DEPTH(DEPTH)) u_iq (
    .clk(clk), .rst_n(rst_n), .push(ret_valid && ret_ready),
    .din({ret_color, ret_void, ret_insn}),
    .pop(dec_pop), .head(hd_entry), .full(insn_full), .empty(insn_empty)
  );

  assign fetch_ready = !pc_full;
  assign ret_ready   = !insn_full;
  assign hd_color    = hd_entry[EW-1];
  assign hd_void     = hd_entry[EW-2];
  assign dec_insn    = hd_entry[INSN_W-1:0];
  assign hd_have     = !insn_empty && !pc_empty;

  // decode point
  assign kind      = classify(hd_have, hd_color == color_q, hd_void, ls_pending);
  assign dec_valid = (kind == DEC_ISSUE);
  assign dec_trap  = (kind == DEC_TRAP);
  assign dec_pop   = (kind == DEC_DROP) ||
                     (((kind == DEC_ISSUE) || (kind == DEC_TRAP)) && dec_ready);
  assign dec_pc_op = pc_operand(dec_pc);
  assign ls_push   = (kind == DEC_ISSUE) && dec_ready && dec_is_ls && !x_full;
  assign ls_pending = mem_ready;

  scu_xcpt #(.PC_W(PC_W), .XDEPTH(XDEPTH)) u_xcpt (
    .clk(clk), .rst_n(rst_n), .ls_push(ls_push), .ls_pc(dec_pc),
    .mem_valid(mem_valid), .mem_abort(mem_abort), .dabt_ack(dabt_ack),
    .mem_ready(mem_ready), .x_full(x_full), .abort_evt(abort_evt),
    .dabt_req(dabt_req), .dabt_ret(dabt_ret)
  );

  // result stage
  assign cm_write = cm_valid && (cm_color == color_q);
endmodule

// File: rtl/scu_checker.sv
module scu_checker (
  input logic clk,
  input logic rst_n,
  input logic ls_pending,
  input logic dec_valid,
  input logic dec_trap,
  input logic hd_void,
  input logic cm_write,
  input logic cm_color,
  input logic fetch_color,
  input logic br_taken,
  input logic abort_evt,
  input logic dabt_req,
  input logic insn_full,
  input logic pc_full
);
  // R7
  hold_after_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_pending |-> (!dec_valid && !dec_trap));
  // R10
  commit_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_write |-> (cm_color == fetch_color));
  // R6
  fifo_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_full |-> pc_full);
  // R2
  branch_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !abort_evt) |=> (fetch_color != $past(fetch_color)));
  // R9
  abort_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> dabt_req);
  // R4
  trap_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_trap |-> hd_void);
endmodule

bind scu_top scu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ls_pending(ls_pending), .dec_valid(dec_valid),
  .dec_trap(dec_trap), .hd_void(hd_void), .cm_write(cm_write),
  .cm_color(cm_color), .fetch_color(fetch_color), .br_taken(br_taken),
  .abort_evt(abort_evt), .dabt_req(dabt_req), .insn_full(insn_full),
  .pc_full(pc_full)
);

// File: tb/scu_top_test.sv
module scu_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 0, ret_valid = 0, ret_color = 0, ret_void = 0;
  logic dec_is_ls = 0, dec_ready = 0, br_taken = 0, cm_valid = 0, cm_color = 0;
  logic mem_valid = 0, mem_abort = 0, dabt_ack = 0;
  logic [31:0] fetch_pc = '0, ret_insn = '0;
  logic fetch_ready, fetch_color, ret_ready, dec_valid, dec_trap, cm_write;
  logic mem_ready, dabt_req;
  logic [31:0] dec_insn, dec_pc, dec_pc_op, dabt_ret;

  int tests = 0, fails = 0;
  bit done = 0;
  logic exp_color = 0;

  always #5 clk = ~clk;

  scu_top uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_ready(fetch_ready), .fetch_color(fetch_color), .ret_valid(ret_valid),
    .ret_insn(ret_insn), .ret_color(ret_color), .ret_void(ret_void),
    .ret_ready(ret_ready), .dec_valid(dec_valid), .dec_trap(dec_trap),
    .dec_insn(dec_insn), .dec_pc(dec_pc), .dec_pc_op(dec_pc_op),
    .dec_is_ls(dec_is_ls), .dec_ready(dec_ready), .br_taken(br_taken),
    .cm_valid(cm_valid), .cm_color(cm_color), .cm_write(cm_write),
    .mem_valid(mem_valid), .mem_abort(mem_abort), .mem_ready(mem_ready),
    .dabt_req(dabt_req), .dabt_ret(dabt_ret), .dabt_ack(dabt_ack)
  );

  // {branch first, return color relative to stream (1 = mismatch), void, expect dec, expect trap}
  localparam logic [4:0] VEC [8] = '{
    5'b0_0_0_1_0, 5'b0_1_0_0_0, 5'b0_1_1_0_0, 5'b0_0_1_0_1,
    5'b1_1_0_0_0, 5'b0_0_0_1_0, 5'b0_0_1_0_1, 5'b1_1_1_0_0
  };

  task automatic cyc;
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch1(input logic [31:0] pc);
    fetch_valid = 1; fetch_pc = pc; cyc; fetch_valid = 0;
  endtask

  task automatic ret1(input logic [31:0] w, input logic c, input logic v);
    ret_valid = 1; ret_insn = w; ret_color = c; ret_void = v; cyc;
    ret_valid = 0; ret_void = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1; #1;
    // R1 reset state
    chk(fetch_color == 0, "R1 color", fetch_color, 0);
    chk(fetch_ready == 1 && dec_valid == 0 && dec_trap == 0, "R1 fifos empty",
        {fetch_ready, dec_valid, dec_trap}, 3'b100);
    chk(mem_ready == 0 && dabt_req == 0, "R1 no pending", {mem_ready, dabt_req}, 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      logic [31:0] pc;
      pc = 32'h1000 + 32'(i * 4);
      if (VEC[i][4]) begin
        br_taken = 1; cyc; br_taken = 0; exp_color = ~exp_color;
      end
      #1 chk(fetch_color == exp_color, "R2 branch toggles color", fetch_color, exp_color);
      fetch1(pc);
      ret1(32'hA000 + 32'(i), exp_color ^ VEC[i][3], VEC[i][2]);
      #1;
      chk(dec_valid == VEC[i][1], "R3 decode color filter", dec_valid, VEC[i][1]);
      chk(dec_trap == VEC[i][0], "R4 void trap", dec_trap, VEC[i][0]);
      if (VEC[i][1]) begin
        chk(dec_pc == pc && dec_insn == 32'hA000 + 32'(i), "R5 pc pairing", dec_pc, pc);
        chk(dec_pc_op == pc + 8, "R5 pc plus 8", dec_pc_op, pc + 8);
      end
      dec_ready = 1; cyc; dec_ready = 0; #1;
      chk(dec_valid == 0 && dec_trap == 0 && fetch_ready == 1, "R3 entry consumed",
          {dec_valid, dec_trap}, 0);
    end

    // R6 prefetch bound
    for (int k = 0; k < 4; k++) begin
      #1 chk(fetch_ready == 1, "R6 room before full", fetch_ready, 1);
      fetch1(32'h2000 + 32'(k * 4));
    end
    #1 chk(fetch_ready == 0, "R6 stall at depth 4", fetch_ready, 0);
    for (int k = 0; k < 4; k++) ret1(32'hB0 + 32'(k), exp_color, 0);
    dec_ready = 1; repeat (4) cyc; dec_ready = 0; #1;
    chk(fetch_ready == 1 && dec_valid == 0, "R6 drained", fetch_ready, 1);

    // R7 R8 hold and no-abort release
    fetch1(32'h3000); fetch1(32'h3004);
    ret1(32'hC0, exp_color, 0); ret1(32'hC1, exp_color, 0);
    #1 chk(dec_valid == 1 && dec_pc == 32'h3000, "R7 ls presented", dec_pc, 32'h3000);
    dec_is_ls = 1; dec_ready = 1; cyc; dec_is_ls = 0; dec_ready = 0; #1;
    chk(dec_valid == 0, "R7 younger held", dec_valid, 0);
    chk(mem_ready == 1, "R7 ls pending", mem_ready, 1);
    cyc; #1 chk(dec_valid == 0, "R7 still held", dec_valid, 0);
    mem_valid = 1; mem_abort = 0; cyc; mem_valid = 0; #1;
    chk(dec_valid == 1 && dec_pc == 32'h3004, "R8 released", dec_pc, 32'h3004);
    chk(dabt_req == 0 && mem_ready == 0, "R8 no abort raised", {dabt_req, mem_ready}, 0);
    dec_ready = 1; cyc; dec_ready = 0;

    // R9 abort path
    fetch1(32'h4000); fetch1(32'h4004);
    ret1(32'hD0, exp_color, 0); ret1(32'hD1, exp_color, 0);
    #1 dec_is_ls = 1; dec_ready = 1; cyc; dec_is_ls = 0; dec_ready = 0;
    mem_valid = 1; mem_abort = 1; cyc; mem_valid = 0; mem_abort = 0;
    exp_color = ~exp_color; #1;
    chk(dabt_req == 1, "R9 abort request", dabt_req, 1);
    chk(dabt_ret == 32'h4008, "R9 return address", dabt_ret, 32'h4008);
    chk(fetch_color == exp_color, "R9 color flipped", fetch_color, exp_color);
    chk(dec_valid == 0, "R9 younger not issued", dec_valid, 0);
    cyc; #1 chk(dec_valid == 0 && fetch_ready == 1, "R9 younger dropped",
                {dec_valid, fetch_ready}, 1);
    dabt_ack = 1; cyc; dabt_ack = 0; #1;
    chk(dabt_req == 0, "R9 ack clears", dabt_req, 0);

    // R10 commit filter
    cm_valid = 1; cm_color = exp_color; #1;
    chk(cm_write == 1, "R10 matching commit", cm_write, 1);
    cm_color = ~exp_color; #1;
    chk(cm_write == 0, "R10 stale commit blocked", cm_write, 0);
    cm_valid = 0; cm_color = exp_color; #1;
    chk(cm_write == 0, "R10 no commit", cm_write, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule